// File: doc/BRIEF.md
# Transmit Modulation Data Source Selector

This block picks the serial bit stream that feeds the transmit modulator and steers the matching transmit data clock to an output pin. Four sources are available: a general-purpose input pin, the serial data-in pin (usable only while chip select is inactive), the bit-serial output of the packet FIFO, and an on-chip 9-bit pseudo-random sequence generator. The chosen bit can be inverted for test.

A bit-rate tick from the modulator timing paces everything. On each tick, while transmit is active, the block loads one new bit into its output register. In FIFO mode it also strobes a request that pulls the next bit out of the FIFO, and in pseudo-random mode it advances the generator. Direct-pin data is sampled at the tick and passed straight through, with no buffering. A one-cycle clock pulse follows each such tick and goes to the pin that the clock field selects, together with that pin's output enable.

Top module: `txsrc_select`

## Requirements
- R1: After reset `mod_data_o` is 0, all three clock pin outputs are 0, and the pseudo-random generator holds all ones.
- R2: A load happens on a clock edge where `bit_tick_i` and `tx_active_i` are both 1. The source field `cfg_i[5:4]` picks the loaded bit: 0 takes `gpio_data_i`, 1 takes `sdi_i`, 2 takes `fifo_bit_i`, 3 takes the generator output. The new value appears on `mod_data_o` after that edge.
- R3: When the source is 1 and `csn_i` is 0, a load leaves `mod_data_o` unchanged.
- R4: `fifo_req_o` is 1 exactly when `bit_tick_i` and `tx_active_i` are both 1 and the source is 2. The FIFO bit present in that cycle is the one that is loaded.
- R5: The generator is a 9-bit register s. Its output bit is s[0]. On a load in source 3 it shifts to {s[0]^s[5], s[8:1]}. It does not shift in any other case.
- R6: `cfg_i[3]` = 1 inverts the loaded bit, for every source.
- R7: Without a load, `mod_data_o` holds its value, the generator does not shift and `fifo_req_o` is 0.
- R8: The clock field `cfg_i[7:6]` enables one pin. 0 enables none, 1 enables `gpio_clk_oe_o`, 2 enables `sdo_clk_oe_o` and 3 enables `irq_clk_oe_o`. The enabled pin goes to 1 for the single cycle that follows a load edge. At most one enable is 1 at any time.
- R9: The serial data-out clock enable and its pin stay 0 while `csn_i` is 0.
- R10: `gfsk_noclk_o` is 1 exactly when the modulation type `cfg_i[1:0]` is 3 (GFSK) and the clock field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 8 | Control register: clock field [7:6], source [5:4], invert [3], deviation MSB [2], modulation type [1:0] |
| tx_active_i | input | 1 | Transmit in progress |
| bit_tick_i | input | 1 | One-cycle bit-rate tick |
| fifo_bit_i | input | 1 | Current head bit of the FIFO |
| fifo_req_o | output | 1 | Pull-next-bit strobe to the FIFO |
| gpio_data_i | input | 1 | Direct data from a general-purpose pin |
| sdi_i | input | 1 | Serial data-in pin |
| csn_i | input | 1 | Chip select, active low |
| mod_data_o | output | 1 | Bit to the modulator |
| gpio_clk_o | output | 1 | Data clock on the general-purpose pin |
| gpio_clk_oe_o | output | 1 | Its output enable |
| sdo_clk_o | output | 1 | Data clock on the serial data-out pin |
| sdo_clk_oe_o | output | 1 | Its output enable |
| irq_clk_o | output | 1 | Data clock on the interrupt pin |
| irq_clk_oe_o | output | 1 | Its output enable |
| gfsk_noclk_o | output | 1 | GFSK selected with no data clock routed |

## Verification
The assertions assume that `cfg_i` and `csn_i` change only between loads and that `bit_tick_i` stays low until the internal reset has been released. Under those conditions a loaded value can be traced back to the inputs of the previous cycle. The stimulus drives every input on the falling edge, raises the tick for exactly one cycle, and changes the configuration only while the tick is low. It waits several cycles after reset release before it issues the first tick.

// File: rtl/txsrc_pkg.sv
package txsrc_pkg;
  typedef enum logic [1:0] {
    SRC_GPIO = 2'd0,
    SRC_SDI  = 2'd1,
    SRC_FIFO = 2'd2,
    SRC_PRBS = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    CKP_NONE = 2'd0,
    CKP_GPIO = 2'd1,
    CKP_SDO  = 2'd2,
    CKP_IRQ  = 2'd3
  } ckpin_e;

  localparam int          CFG_CK_LSB  = 6;
  localparam int          CFG_SRC_LSB = 4;
  localparam int          CFG_INV_BIT = 3;
  localparam logic [1:0]  MODT_GFSK   = 2'b11;
endpackage

// File: rtl/txsrc_prbs.sv
module txsrc_prbs #(
  parameter int LEN = 9,
  parameter int TAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic bit_o
);
  logic [LEN-1:0] st_q, st_d;

  always_comb begin
    st_d = {st_q[0] ^ st_q[TAP], st_q[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '1;
    else if (adv_i) st_q <= st_d;
  end

  assign bit_o = st_q[0];
endmodule

// File: rtl/txsrc_clkroute.sv
module txsrc_clkroute
  import txsrc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ckpin_e pin_sel_i,
  input  logic   csn_i,
  input  logic   load_i,
  output logic   gpio_clk_o,
  output logic   gpio_oe_o,
  output logic   sdo_clk_o,
  output logic   sdo_oe_o,
  output logic   irq_clk_o,
  output logic   irq_oe_o
);
  logic pulse_q, pulse_d;

  always_comb pulse_d = load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  always_comb begin
    gpio_oe_o = (pin_sel_i == CKP_GPIO);
    sdo_oe_o  = (pin_sel_i == CKP_SDO) && csn_i;
    irq_oe_o  = (pin_sel_i == CKP_IRQ);
    gpio_clk_o = pulse_q & gpio_oe_o;
    sdo_clk_o  = pulse_q & sdo_oe_o;
    irq_clk_o  = pulse_q & irq_oe_o;
  end
endmodule

// File: rtl/txsrc_select.sv
module txsrc_select
  import txsrc_pkg::*;
#(
  parameter int PN_LEN = 9,
  parameter int PN_TAP = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_i,
  input  logic       tx_active_i,
  input  logic       bit_tick_i,
  input  logic       fifo_bit_i,
  output logic       fifo_req_o,
  input  logic       gpio_data_i,
  input  logic       sdi_i,
  input  logic       csn_i,
  output logic       mod_data_o,
  output logic       gpio_clk_o,
  output logic       gpio_clk_oe_o,
  output logic       sdo_clk_o,
  output logic       sdo_clk_oe_o,
  output logic       irq_clk_o,
  output logic       irq_clk_oe_o,
  output logic       gfsk_noclk_o
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_q = rst_sync_q[SYNC_MSB];

  src_e   src;
  ckpin_e ckp;
  logic   inv;
  logic   load, pn_bit, pick;
  logic   data_q, data_d;

  always_comb begin
    src  = src_e'(cfg_i[CFG_SRC_LSB +: 2]);
    ckp  = ckpin_e'(cfg_i[CFG_CK_LSB +: 2]);
    inv  = cfg_i[CFG_INV_BIT];
    load = bit_tick_i & tx_active_i;
  end

  txsrc_prbs #(.LEN(PN_LEN), .TAP(PN_TAP)) u_prbs (
    .clk   (clk),
    .rst_n (rst_q),
    .adv_i (load && (src == SRC_PRBS)),
    .bit_o (pn_bit)
  );

  always_comb begin
    data_d = data_q;
    pick   = 1'b0;
    unique case (src)
      SRC_GPIO: pick = gpio_data_i;
      SRC_SDI:  pick = sdi_i;
      SRC_FIFO: pick = fifo_bit_i;
      SRC_PRBS: pick = pn_bit;
    endcase
    if (load && !(src == SRC_SDI && !csn_i))
      data_d = pick ^ inv;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) data_q <= 1'b0;
    else        data_q <= data_d;
  end

  assign mod_data_o   = data_q;
  assign fifo_req_o   = load && (src == SRC_FIFO);
  assign gfsk_noclk_o = (cfg_i[1:0] == MODT_GFSK) && (ckp == CKP_NONE);

  txsrc_clkroute u_ckr (
    .clk        (clk),
    .rst_n      (rst_q),
    .pin_sel_i  (ckp),
    .csn_i      (csn_i),
    .load_i     (load),
    .gpio_clk_o (gpio_clk_o),
    .gpio_oe_o  (gpio_clk_oe_o),
    .sdo_clk_o  (sdo_clk_o),
    .sdo_oe_o   (sdo_clk_oe_o),
    .irq_clk_o  (irq_clk_o),
    .irq_oe_o   (irq_clk_oe_o)
  );
endmodule

// File: rtl/txsrc_chk.sv
module txsrc_chk (
  input logic       clk,
  input logic       rst_q,
  input logic [7:0] cfg_i,
  input logic       tx_active_i,
  input logic       bit_tick_i,
  input logic       fifo_bit_i,
  input logic       fifo_req_o,
  input logic       csn_i,
  input logic       mod_data_o,
  input logic       gpio_clk_oe_o,
  input logic       sdo_clk_oe_o,
  input logic       sdo_clk_o,
  input logic       irq_clk_oe_o
);
  // R4
  fifo_req_mode_chk: assert property (@(posedge clk) disable iff (!rst_q)
    fifo_req_o |-> (cfg_i[5:4] == 2'd2 && tx_active_i && bit_tick_i));

  // R4
  fifo_bit_taken_chk: assert property (@(posedge clk) disable iff (!rst_q)
    fifo_req_o |=> (mod_data_o == ($past(fifo_bit_i) ^ $past(cfg_i[3]))));

  // R7
  hold_no_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(bit_tick_i && tx_active_i) |=> $stable(mod_data_o));

  // R3
  sdi_blocked_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cfg_i[5:4] == 2'd1 && !csn_i) |=> $stable(mod_data_o));

  // R8
  one_pin_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({gpio_clk_oe_o, sdo_clk_oe_o, irq_clk_oe_o}));

  // R9
  sdo_csn_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (sdo_clk_oe_o || sdo_clk_o) |-> csn_i);
endmodule

bind txsrc_select txsrc_chk u_chk (
  .clk           (clk),
  .rst_q         (rst_q),
  .cfg_i         (cfg_i),
  .tx_active_i   (tx_active_i),
  .bit_tick_i    (bit_tick_i),
  .fifo_bit_i    (fifo_bit_i),
  .fifo_req_o    (fifo_req_o),
  .csn_i         (csn_i),
  .mod_data_o    (mod_data_o),
  .gpio_clk_oe_o (gpio_clk_oe_o),
  .sdo_clk_oe_o  (sdo_clk_oe_o),
  .sdo_clk_o     (sdo_clk_o),
  .irq_clk_oe_o  (irq_clk_oe_o)
);

// File: tb/txsrc_select_tb.sv
`timescale 1ns/1ps
module txsrc_select_tb;
  logic clk, rst_n;
  logic [7:0] cfg;
  logic active, tick, fbit, gpio, sdi, csn;
  logic req, mdat, gck, goe, sck, soe, ick, ioe, gnc;
  logic req_seen;
  int   checks = 0, errors = 0;
  logic [8:0] pn;

  txsrc_select u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .tx_active_i(active),
    .bit_tick_i(tick), .fifo_bit_i(fbit), .fifo_req_o(req),
    .gpio_data_i(gpio), .sdi_i(sdi), .csn_i(csn), .mod_data_o(mdat),
    .gpio_clk_o(gck), .gpio_clk_oe_o(goe), .sdo_clk_o(sck),
    .sdo_clk_oe_o(soe), .irq_clk_o(ick), .irq_clk_oe_o(ioe),
    .gfsk_noclk_o(gnc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pn = 9'h1FF;
  endtask

  task automatic step(input logic g, input logic s, input logic f, input logic a);
    gpio = g; sdi = s; fbit = f; active = a; tick = 1'b1;
    #1 req_seen = req;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfg = 8'h23; active = 0; tick = 0; fbit = 0; gpio = 0; sdi = 0; csn = 1;
    rst_n = 1'b0;
    @(negedge clk);
    // R1: state during and after reset
    do_reset();
    chk("R1 mod_data", mdat, 1'b0);
    chk("R1 gpio_clk", gck, 1'b0);
    chk("R1 sdo_clk", sck, 1'b0);
    chk("R1 irq_clk", ick, 1'b0);

    // R2 R4 R5 R6: sweep every source with and without inversion
    for (int s = 0; s < 4; s++) begin
      for (int iv = 0; iv < 2; iv++) begin
        cfg = {2'b00, s[1:0], iv[0], 3'b000};
        csn = 1'b1;
        do_reset();
        for (int i = 0; i < 12; i++) begin
          logic g, d, f, e;
          g = ((i * 5 + s) >> 1) & 1;
          d = ((i * 3 + iv) >> 1) & 1;
          f = ((i * 7 + 1) >> 2) & 1;
          case (s)
            0: e = g;
            1: e = d;
            2: e = f;
            default: begin
              e = pn[0];
              pn = {pn[0] ^ pn[5], pn[8:1]};
            end
          endcase
          e = e ^ iv[0];
          step(g, d, f, 1'b1);
          chk((s == 3) ? "R5 prbs bit" : (iv ? "R6 inverted" : "R2 source"), mdat, e);
          chk("R4 fifo_req", req_seen, (s == 2));
        end
      end
    end

    // R3: serial data-in blocked while chip select is low
    cfg = 8'h10; csn = 1'b1;
    step(0, 1, 0, 1);
    chk("R3 sdi csn high", mdat, 1'b1);
    csn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(1, i[0], 1, 1);
      chk("R3 sdi held", mdat, 1'b1);
    end
    csn = 1'b1;

    // R7: no load while transmit inactive; PRBS does not shift
    cfg = 8'h30;
    do_reset();
    step(0, 0, 0, 1);
    chk("R5 first", mdat, pn[0]);
    pn = {pn[0] ^ pn[5], pn[8:1]};
    for (int i = 0; i < 5; i++) begin
      logic hold;
      hold = mdat;
      step(~hold, ~hold, ~hold, 1'b0);
      chk("R7 held", mdat, hold);
      chk("R7 no req", req_seen, 1'b0);
    end
    cfg = 8'h20;
    step(0, 0, 1, 1'b0);
    chk("R7 fifo no req", req_seen, 1'b0);
    cfg = 8'h30;
    for (int i = 0; i < 4; i++) begin
      logic e;
      e = pn[0];
      pn = {pn[0] ^ pn[5], pn[8:1]};
      step(0, 0, 0, 1);
      chk("R7 prbs resumes", mdat, e);
    end

    // R8 R9: clock pin routing
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 2; c++) begin
        cfg = {k[1:0], 6'b000000};
        csn = c[0];
        #1;
        chk("R8 gpio oe", goe, (k == 1));
        chk("R9 sdo oe", soe, (k == 2) && c[0]);
        chk("R8 irq oe", ioe, (k == 3));
        @(negedge clk);
        step(0, 0, 0, 1);
        chk("R8 gpio pulse", gck, (k == 1));
        chk("R9 sdo pulse", sck, (k == 2) && c[0]);
        chk("R8 irq pulse", ick, (k == 3));
        @(negedge clk);
        chk("R8 pulse ends", gck | sck | ick, 1'b0);
        step(0, 0, 0, 0);
        chk("R8 no pulse inactive", gck | sck | ick, 1'b0);
      end
    end
    csn = 1'b1;

    // R10: GFSK without a routed clock
    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 4; m++) begin
        cfg = {k[1:0], 4'b0000, m[1:0]};
        #1;
        chk("R10 gfsk flag", gnc, (m == 3) && (k == 0));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule